// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block produces the 16-bit time base that compare and output stages of a PWM generator run from. A clock prescaler built from two cascaded stages (one binary, one linear with a bypass at zero) turns the system clock into a tick. On every allowed tick the counter steps in one of four modes: up, down, up-down or frozen. The counter publishes its value together with a strobe on arrival at zero and a strobe on arrival at the period.

A 16-bit configuration word selects the count mode, the run mode, the two prescaler fields and how a period write is taken. A period write lands directly in the active period, or in a shadow copy that moves to the active period when the counter next arrives at zero. The run mode either halts the counter at once, lets it finish the current cycle and stop at zero, or leaves it running. Everything sits in one clock domain with a synchronous active-high reset.

Top module: `pwm_timebase`

## Requirements
- R1: Configuration word fields are: [15:14] run mode, [12:10] binary divider B, [9:7] linear divider L, [3] period load select, [1:0] count mode. The counter may advance exactly once every (2^B)*(L==0 ? 1 : 2*L) clocks. A configuration write restarts the prescaler, and no advance happens on the clock edge that takes the write.
- R2: Count mode 00 (up) steps 0,1,...,P and then returns to 0, where P is the active period.
- R3: Count mode 01 (down) steps from 0 to P, then counts down to 0 and repeats.
- R4: Count mode 10 (up-down) counts up to P, turns and counts down to 0, then turns again. With P equal to 0 the counter stays at 0.
- R5: Count mode 11 (freeze) holds the counter value and raises no strobe.
- R6: Run mode 00 holds the counter from the write onward and raises no strobe.
- R7: Run mode 01 lets the counter advance until it arrives at 0 and then holds it at 0. Run modes 10 and 11 run freely.
- R8: With load select 1, a period write becomes the active period on the clock edge that takes it.
- R9: With load select 0, a period write goes to the shadow copy only. The active period takes the shadow value on the edge where the counter arrives at 0.
- R10: tb_zero and tb_match are single-clock pulses. Each appears together with a counter update that lands on 0 or on the active period (the value held before that edge), respectively.
- R11: After reset the count is 0, both strobes are low, the configuration word is 0 (halted, up, shadow load) and both period registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 16 | Configuration word value |
| prd_we | input | 1 | Period write strobe |
| prd_wdata | input | 16 | Period value |
| tb_count | output | 16 | Registered counter value |
| tb_zero | output | 1 | Pulse: counter update landed on zero |
| tb_match | output | 1 | Pulse: counter update landed on the period |

## Verification
Let E0 be the edge that takes a configuration write. The first advance then falls on edge E0+N, with N the prescale ratio, and later advances fall every N edges after it. The count and both strobes are registered, so each is visible right after the edge that advances the counter. Inputs are driven and outputs sampled on the falling edge. In the sweeps, expected values are indexed by j, the number of edges since E0: the expected count follows the mode's closed-form sequence at floor(j/N) ticks, and a strobe is expected only when j is a multiple of N. In the directed cases every write edge is counted, including the ones that advance the counter through an unchanged prescaler.

// File: rtl/pwm_tb_pkg.sv
package pwm_tb_pkg;

  typedef enum logic [1:0] {
    CM_UP   = 2'b00,
    CM_DOWN = 2'b01,
    CM_UPDN = 2'b10,
    CM_FRZ  = 2'b11
  } cmode_e;

  typedef enum logic [1:0] {
    RM_HALT  = 2'b00,
    RM_CYCLE = 2'b01,
    RM_FREEA = 2'b10,
    RM_FREE  = 2'b11
  } rmode_e;

  typedef struct packed {
    rmode_e     run;
    logic [2:0] bdiv;
    logic [2:0] ldiv;
    logic       imm;
    cmode_e     mode;
  } cfg_t;

  function automatic cfg_t decode_cfg(input logic [15:0] w);
    cfg_t c;
    c.run  = rmode_e'(w[15:14]);
    c.bdiv = w[12:10];
    c.ldiv = w[9:7];
    c.imm  = w[3];
    c.mode = cmode_e'(w[1:0]);
    return c;
  endfunction

endpackage

// File: rtl/pwm_tb_prescaler.sv
module pwm_tb_prescaler #(
  parameter int BW = 3,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [BW-1:0] bsel,
  input  logic [LW-1:0] lsel,
  output logic          tick
);
  localparam int C1W = (1 << BW) - 1;
  localparam int C2W = LW + 1;

  logic [C1W-1:0] c1_q, c1_last;
  logic [C2W-1:0] c2_q, c2_last;
  logic           c1_end, c2_end;

  always_comb begin
    c1_last = C1W'((32'd1 << bsel) - 32'd1);
    c2_last = (lsel == '0) ? '0 : ({lsel, 1'b0} - C2W'(1));
  end

  assign c1_end = (c1_q == c1_last);
  assign c2_end = (c2_q == c2_last);
  assign tick   = c1_end && c2_end && !clr;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      c1_q <= '0;
      c2_q <= '0;
    end else if (c1_end) begin
      c1_q <= '0;
      c2_q <= c2_end ? '0 : c2_q + C2W'(1);
    end else begin
      c1_q <= c1_q + C1W'(1);
    end
  end

  assert_tick_spacing_R1 : assert property (@(posedge clk) disable iff (rst)
    (tick && !clr && ((c1_last != '0) || (c2_last != '0))) |=> !tick);

endmodule

// File: rtl/pwm_tb_period.sv
module pwm_tb_period #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  logic         imm,
  input  logic         load,
  output logic [W-1:0] act_o
);
  logic [W-1:0] shd_q, act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shd_q <= '0;
      act_q <= '0;
    end else begin
      if (we) shd_q <= wdata;
      if (we && imm)  act_q <= wdata;
      else if (load)  act_q <= shd_q;
    end
  end

  assign act_o = act_q;

  assert_imm_load_R8 : assert property (@(posedge clk) disable iff (rst)
    (we && imm) |=> (act_q == $past(wdata)));

  assert_shadow_hold_R9 : assert property (@(posedge clk) disable iff (rst)
    (!we && !load) |=> $stable(act_q));

endmodule

// File: rtl/pwm_tb_counter.sv
module pwm_tb_counter
  import pwm_tb_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  cmode_e       mode,
  input  rmode_e       run,
  input  logic [W-1:0] act,
  output logic [W-1:0] cnt_o,
  output logic         zero_o,
  output logic         match_o,
  output logic         land_zero
);
  logic [W-1:0] cnt_q, nxt;
  logic         up_q, nup, allow, adv;

  always_comb begin
    nxt = cnt_q;
    nup = up_q;
    unique case (mode)
      CM_UP:   nxt = (cnt_q >= act) ? '0 : cnt_q + W'(1);
      CM_DOWN: nxt = (cnt_q == '0) ? act : cnt_q - W'(1);
      CM_UPDN: begin
        if (act == '0) begin
          nxt = '0;
        end else if (up_q) begin
          if (cnt_q >= act) begin
            nup = 1'b0;
            nxt = cnt_q - W'(1);
          end else begin
            nxt = cnt_q + W'(1);
          end
        end else begin
          if (cnt_q == '0) begin
            nup = 1'b1;
            nxt = cnt_q + W'(1);
          end else begin
            nxt = cnt_q - W'(1);
          end
        end
      end
      default: nxt = cnt_q;
    endcase
  end

  always_comb begin
    unique case (run)
      RM_HALT:  allow = 1'b0;
      RM_CYCLE: allow = (cnt_q != '0);
      default:  allow = 1'b1;
    endcase
  end

  assign adv       = tick && allow && (mode != CM_FRZ);
  assign land_zero = adv && (nxt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      up_q    <= 1'b1;
      zero_o  <= 1'b0;
      match_o <= 1'b0;
    end else begin
      zero_o  <= adv && (nxt == '0);
      match_o <= adv && (nxt == act);
      if (adv) begin
        cnt_q <= nxt;
        up_q  <= nup;
      end
    end
  end

  assign cnt_o = cnt_q;

  assert_freeze_hold_R5 : assert property (@(posedge clk) disable iff (rst)
    (mode == CM_FRZ) |=> ($stable(cnt_q) && !zero_o && !match_o));

  assert_halt_hold_R6 : assert property (@(posedge clk) disable iff (rst)
    (run == RM_HALT) |=> ($stable(cnt_q) && !zero_o && !match_o));

  assert_cycle_stop_R7 : assert property (@(posedge clk) disable iff (rst)
    (run == RM_CYCLE && cnt_q == '0) |=> (cnt_q == '0));

  assert_zero_strobe_R10 : assert property (@(posedge clk) disable iff (rst)
    zero_o |-> (cnt_q == '0));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_tb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [15:0]      cfg_wdata,
  input  logic             prd_we,
  input  logic [CNT_W-1:0] prd_wdata,
  output logic [CNT_W-1:0] tb_count,
  output logic             tb_zero,
  output logic             tb_match
);
  logic [15:0]      cfg_q;
  cfg_t             cfg;
  logic             tick, land_zero;
  logic [CNT_W-1:0] act_prd;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_wdata;
  end

  assign cfg = decode_cfg(cfg_q);

  pwm_tb_prescaler #(.BW(3), .LW(3)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .clr  (cfg_we),
    .bsel (cfg.bdiv),
    .lsel (cfg.ldiv),
    .tick (tick)
  );

  pwm_tb_period #(.W(CNT_W)) u_prd (
    .clk   (clk),
    .rst   (rst),
    .we    (prd_we),
    .wdata (prd_wdata),
    .imm   (cfg.imm),
    .load  (land_zero),
    .act_o (act_prd)
  );

  pwm_tb_counter #(.W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .mode      (cfg.mode),
    .run       (cfg.run),
    .act       (act_prd),
    .cnt_o     (tb_count),
    .zero_o    (tb_zero),
    .match_o   (tb_match),
    .land_zero (land_zero)
  );

  assert_strobe_excl_R10 : assert property (@(posedge clk) disable iff (rst)
    (tb_zero && tb_match) |-> (act_prd == '0 || $past(act_prd) == '0 || prd_we || $past(prd_we)));

endmodule

// File: tb/pwm_timebase_tb_top.sv
module pwm_timebase_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        prd_we = 1'b0;
  logic [15:0] prd_wdata = '0;
  logic [15:0] tb_count;
  logic        tb_zero, tb_match;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  pwm_timebase dut_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .prd_we    (prd_we),
    .prd_wdata (prd_wdata),
    .tb_count  (tb_count),
    .tb_zero   (tb_zero),
    .tb_match  (tb_match)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] cw(int run, int bd, int ld, int imm, int mode);
    return 16'((run << 14) | (bd << 10) | (ld << 7) | (imm << 3) | mode);
  endfunction

  task automatic wr_cfg(input logic [15:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic wr_prd(input int v);
    prd_we = 1'b1; prd_wdata = 16'(v);
    step();
    prd_we = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic start(int mode, int p, int bd, int ld, int imm);
    do_reset();
    wr_cfg(cw(0, 0, 0, 1, 0));
    wr_prd(p);
    wr_cfg(cw(3, bd, ld, imm, mode));
  endtask

  function automatic int exp_val(int mode, int p, int k);
    int t;
    if (mode == 0) return k % (p + 1);
    if (mode == 1) return (p + 1 - (k % (p + 1))) % (p + 1);
    if (p == 0) return 0;
    t = k % (2 * p);
    return (t <= p) ? t : 2 * p - t;
  endfunction

  task automatic expect_step(string req, int c, int z, int m);
    step();
    chk({req, " count"}, int'(tb_count), c);
    chk({req, " zero"}, int'(tb_zero), z);
    chk({req, " match"}, int'(tb_match), m);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    int plist[4];
    plist = '{0, 1, 2, 5};
    @(negedge clk);
    do_reset();
    // R11: reset state, halted by default
    for (int i = 0; i < 4; i++) begin
      chk("R11 count", int'(tb_count), 0);
      chk("R11 zero", int'(tb_zero), 0);
      chk("R11 match", int'(tb_match), 0);
      step();
    end

    // R1 R2 R3 R4 R10: sweep modes, periods and prescaler settings
    for (int mode = 0; mode < 3; mode++)
      for (int pi = 0; pi < 4; pi++)
        for (int bd = 0; bd < 3; bd++)
          for (int ld = 0; ld < 4; ld++) begin
            int p, n, ticks, k, v;
            string req;
            p = plist[pi];
            n = (1 << bd) * ((ld == 0) ? 1 : 2 * ld);
            ticks = ((mode == 2) ? 2 * p : p + 1) * 2 + 2;
            req = (mode == 0) ? "R1/R2" : (mode == 1) ? "R1/R3" : "R1/R4";
            start(mode, p, bd, ld, 1);
            chk({req, " after write"}, int'(tb_count), 0);
            for (int j = 1; j <= ticks * n; j++) begin
              step();
              k = j / n;
              v = exp_val(mode, p, k);
              chk(req, int'(tb_count), v);
              chk("R10 zero", int'(tb_zero), (j % n == 0 && v == 0) ? 1 : 0);
              chk("R10 match", int'(tb_match), (j % n == 0 && v == p) ? 1 : 0);
            end
          end

    // R6: halt holds the counter
    start(0, 5, 0, 0, 1);
    step(); step(); step();
    chk("R6 pre", int'(tb_count), 3);
    wr_cfg(cw(0, 0, 0, 1, 0));
    chk("R6 write edge", int'(tb_count), 3);
    for (int i = 0; i < 4; i++) expect_step("R6", 3, 0, 0);
    wr_cfg(cw(3, 0, 0, 1, 0));
    expect_step("R6 resume", 4, 0, 0);
    expect_step("R6 resume", 5, 0, 1);
    expect_step("R6 resume", 0, 1, 0);

    // R5: freeze mode holds
    start(0, 5, 0, 0, 1);
    step(); step();
    wr_cfg(cw(3, 0, 0, 1, 3));
    for (int i = 0; i < 4; i++) expect_step("R5", 2, 0, 0);

    // R7: run-to-zero in up-down mode
    start(2, 3, 0, 0, 1);
    step(); step();
    chk("R7 pre", int'(tb_count), 2);
    wr_cfg(cw(1, 0, 0, 1, 2));
    expect_step("R7", 3, 0, 1);
    expect_step("R7", 2, 0, 0);
    expect_step("R7", 1, 0, 0);
    expect_step("R7", 0, 1, 0);
    for (int i = 0; i < 3; i++) expect_step("R7 hold", 0, 0, 0);

    // R9: shadow period moves to active at zero
    start(0, 5, 0, 0, 0);
    step(); step();
    wr_prd(2);
    chk("R9 write edge", int'(tb_count), 3);
    expect_step("R9 old period", 4, 0, 0);
    expect_step("R9 old period", 5, 0, 1);
    expect_step("R9 transfer", 0, 1, 0);
    expect_step("R9 new period", 1, 0, 0);
    expect_step("R9 new period", 2, 0, 1);
    expect_step("R9 new period", 0, 1, 0);

    // R8: immediate period load
    start(0, 5, 0, 0, 1);
    step(); step();
    wr_prd(3);
    chk("R8 write edge", int'(tb_count), 3);
    expect_step("R8", 0, 1, 0);
    expect_step("R8", 1, 0, 0);
    expect_step("R8", 2, 0, 0);
    expect_step("R8", 3, 0, 1);
    expect_step("R8", 0, 1, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule